// File: doc/BRIEF.md
# Embedded Operation Status Reporter

This block builds the byte a host reads back from a flash device while an internal program or erase operation is running. The embedded engine starts an operation with a single-cycle `op_start` pulse. The pulse carries the target byte, the current cell contents and, for an erase, a mask of the sectors being erased. The engine later reports completion with `eng_done` or a time-limit overrun with `eng_timeout`.

While an operation is active, reads that fall under it return a status byte in place of array data. The byte carries three flags:
- bit 7 is the polling flag;
- bit 6 flips on every read;
- bit 5 is the error flag.

A timeout is sticky. The error flag stays high and bit 6 keeps flipping until the command decoder sends `reset_cmd`, which returns the block to plain read mode. After a clean `eng_done`, reads pass array data through again, so the host sees the true written byte.

Reads use a request channel (`rq_valid`/`rq_ready` with `rq_addr`) and a response channel (`rs_valid`/`rs_ready` with `rs_data`). A request is taken on a cycle where both `rq_valid` and `rq_ready` are high. The block samples `arr_data`, the array byte for `rq_addr`, in that same cycle, and the response appears on the next cycle. `rq_ready` is high when no response is held, or when the held response is being taken in that cycle. A response stays unchanged until the host takes it with `rs_ready`. Control pins are plain single-cycle pulses.

Top module: `flash_status_reporter`

## Requirements
- R1: After reset, `rs_valid` is 0, `rq_ready` is 1 and the block is in read mode.
- R2: In read mode, each accepted request returns the `arr_data` sampled at acceptance, with `rs_valid` high on the following cycle.
- R3: A response that the host does not take (`rs_valid` high, `rs_ready` low) keeps `rs_valid` high and `rs_data` unchanged on the next cycle. `rq_ready` is low only while such a response waits.
- R4: During a program operation, every read returns a status byte. Its bit 7 is the inverse of bit 7 of the target byte, bit 5 is 0 and bits 4..0 are 0.
- R5: Bit 6 of the status byte is 0 on the first read after an operation starts. It inverts after every request accepted while an operation or fault is active, whether or not that read returned status. It returns to 0 once read mode is re-entered.
- R6: During an erase, a read whose sector (the top 3 address bits with default parameters) is set in the erase mask returns status with bit 7 = 0. Reads in other sectors return `arr_data`.
- R7: `eng_done` during an operation returns the block to read mode, and later reads return `arr_data`.
- R8: `eng_timeout` during an operation enters the fault state. Status reads then carry bit 5 = 1, bit 6 keeps inverting, and bit 7 and sector selection stay as for the failed operation. `eng_done` has no effect in the fault state.
- R9: `reset_cmd` in the fault state returns to read mode. `reset_cmd` and `op_start` during a running operation are ignored.
- R10: A program start whose target byte has a 1 where `op_cell` has a 0 enters the fault state at once.
- R11: When `eng_timeout` and `eng_done` arrive in the same cycle, the timeout wins and the fault state is entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_start | input | 1 | Engine starts an operation (pulse) |
| op_erase | input | 1 | 1 = erase, 0 = program, sampled with `op_start` |
| op_data | input | 8 | Target byte of a program |
| op_cell | input | 8 | Current cell contents at the program address |
| op_sectors | input | 8 | Erase sector mask, one bit per sector |
| eng_done | input | 1 | Operation finished (pulse) |
| eng_timeout | input | 1 | Operation exceeded its time limit (pulse) |
| reset_cmd | input | 1 | Reset command from the command decoder (pulse) |
| rq_valid | input | 1 | Read request valid |
| rq_ready | output | 1 | Read request can be taken |
| rq_addr | input | 18 | Read address |
| arr_data | input | 8 | Array byte for `rq_addr`, same cycle |
| rs_valid | output | 1 | Response valid |
| rs_ready | input | 1 | Host takes the response |
| rs_data | output | 8 | Response byte (array data or status) |

## Verification
The assertions take three things for granted:
- `arr_data` is valid for `rq_addr` in the same cycle a request is taken;
- `op_start` is only meaningful in read mode;
- every control input is a pulse lasting one cycle.

The bench drives `arr_data` combinationally from `rq_addr` through a fixed function of the address. It raises each control pulse for exactly one cycle, between reads, and holds a request steady until it is taken. Stalls on `rs_ready` are applied in a repeating pattern, so the hold rule is exercised while the toggle keeps counting accepted requests.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  typedef enum logic [1:0] {
    MODE_READ  = 2'd0,
    MODE_PROG  = 2'd1,
    MODE_ERASE = 2'd2,
    MODE_FAULT = 2'd3
  } mode_e;

  localparam int BYTE_W  = 8;
  localparam int BIT_POLL = 7;
  localparam int BIT_TGL  = 6;
  localparam int BIT_ERR  = 5;
endpackage

// File: rtl/fsr_mode_ctl.sv
module fsr_mode_ctl
  import fsr_pkg::*;
#(
  parameter int NUM_SECT = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 op_start,
  input  logic                 op_erase,
  input  logic [BYTE_W-1:0]    op_data,
  input  logic [BYTE_W-1:0]    op_cell,
  input  logic [NUM_SECT-1:0]  op_sectors,
  input  logic                 eng_done,
  input  logic                 eng_timeout,
  input  logic                 reset_cmd,
  output mode_e                mode,
  output logic                 kind_erase,
  output logic                 poll_bit,
  output logic [NUM_SECT-1:0]  sect_mask
);
  mode_e mode_q, mode_d;
  logic  kind_q, poll_q;
  logic [NUM_SECT-1:0] mask_q;
  logic  bad_prog;
  logic  take_start;

  // a program can only clear bits; any 0 -> 1 request fails at once
  assign bad_prog   = !op_erase && (|(op_data & ~op_cell));
  assign take_start = (mode_q == MODE_READ) && op_start;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_READ:
        if (op_start) mode_d = bad_prog ? MODE_FAULT
                                        : (op_erase ? MODE_ERASE : MODE_PROG);
      MODE_PROG, MODE_ERASE:
        if (eng_timeout)   mode_d = MODE_FAULT;
        else if (eng_done) mode_d = MODE_READ;
      MODE_FAULT:
        if (reset_cmd) mode_d = MODE_READ;
      default: mode_d = MODE_READ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_READ;
      kind_q <= 1'b0;
      poll_q <= 1'b0;
      mask_q <= '0;
    end else begin
      mode_q <= mode_d;
      if (take_start) begin
        kind_q <= op_erase;
        poll_q <= ~op_data[BIT_POLL] & ~op_erase;
        mask_q <= op_erase ? op_sectors : '0;
      end
    end
  end

  assign mode       = mode_q;
  assign kind_erase = kind_q;
  assign poll_bit   = poll_q;
  assign sect_mask  = mask_q;

  p_timeout_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MODE_PROG || mode_q == MODE_ERASE) && eng_timeout)
      |=> (mode_q == MODE_FAULT));

  p_fault_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_FAULT && !reset_cmd) |=> (mode_q == MODE_FAULT));

  p_busy_keeps_op_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != MODE_READ) |=> ($stable(kind_q) && $stable(poll_q) && $stable(mask_q)));

  p_bad_program_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_READ && op_start && !op_erase && (|(op_data & ~op_cell)))
      |=> (mode_q == MODE_FAULT));
endmodule

// File: rtl/fsr_toggle.sv
module fsr_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic adv,
  output logic tgl
);
  logic tgl_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       tgl_q <= 1'b0;
    else if (!active) tgl_q <= 1'b0;
    else if (adv)     tgl_q <= ~tgl_q;
  end

  assign tgl = tgl_q;

  p_fresh_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> !tgl_q);
endmodule

// File: rtl/fsr_status_mux.sv
module fsr_status_mux
  import fsr_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int SECT_W = 3
) (
  input  mode_e                      mode,
  input  logic                       kind_erase,
  input  logic                       poll_bit,
  input  logic [(1<<SECT_W)-1:0]     sect_mask,
  input  logic                       tgl,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [BYTE_W-1:0]          arr_data,
  output logic [BYTE_W-1:0]          byte_out
);
  localparam int NUM_SECT = 1 << SECT_W;

  logic [SECT_W-1:0]   sect;
  logic [NUM_SECT-1:0] sect_sel;
  logic prog_like, erase_like, sect_hit, use_status;
  logic [BYTE_W-1:0] status;

  assign sect = addr[ADDR_W-1 -: SECT_W];

  for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect_dec
    assign sect_sel[s] = (sect == SECT_W'(s));
  end

  assign sect_hit   = |(sect_sel & sect_mask);
  assign prog_like  = (mode == MODE_PROG)  || (mode == MODE_FAULT && !kind_erase);
  assign erase_like = (mode == MODE_ERASE) || (mode == MODE_FAULT &&  kind_erase);
  assign use_status = prog_like || (erase_like && sect_hit);

  always_comb begin
    status           = '0;
    status[BIT_POLL] = poll_bit;
    status[BIT_TGL]  = tgl;
    status[BIT_ERR]  = (mode == MODE_FAULT);
  end

  assign byte_out = use_status ? status : arr_data;
endmodule

// File: rtl/flash_status_reporter.sv
module flash_status_reporter
  import fsr_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int SECT_W = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       op_start,
  input  logic                       op_erase,
  input  logic [7:0]                 op_data,
  input  logic [7:0]                 op_cell,
  input  logic [(1<<SECT_W)-1:0]     op_sectors,
  input  logic                       eng_done,
  input  logic                       eng_timeout,
  input  logic                       reset_cmd,
  input  logic                       rq_valid,
  output logic                       rq_ready,
  input  logic [ADDR_W-1:0]          rq_addr,
  input  logic [7:0]                 arr_data,
  output logic                       rs_valid,
  input  logic                       rs_ready,
  output logic [7:0]                 rs_data
);
  localparam int NUM_SECT = 1 << SECT_W;

  mode_e mode;
  logic  kind_erase, poll_bit, tgl, active, accept;
  logic [NUM_SECT-1:0] sect_mask;
  logic [BYTE_W-1:0]   next_byte;
  logic                rs_valid_q;
  logic [BYTE_W-1:0]   rs_data_q;

  assign rq_ready = !rs_valid_q || rs_ready;
  assign accept   = rq_valid && rq_ready;
  assign active   = (mode != MODE_READ);

  fsr_mode_ctl #(.NUM_SECT(NUM_SECT)) u_mode (
    .clk(clk), .rst_n(rst_n),
    .op_start(op_start), .op_erase(op_erase), .op_data(op_data),
    .op_cell(op_cell), .op_sectors(op_sectors),
    .eng_done(eng_done), .eng_timeout(eng_timeout), .reset_cmd(reset_cmd),
    .mode(mode), .kind_erase(kind_erase), .poll_bit(poll_bit),
    .sect_mask(sect_mask)
  );

  fsr_toggle u_tgl (
    .clk(clk), .rst_n(rst_n), .active(active), .adv(accept), .tgl(tgl)
  );

  fsr_status_mux #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_mux (
    .mode(mode), .kind_erase(kind_erase), .poll_bit(poll_bit),
    .sect_mask(sect_mask), .tgl(tgl), .addr(rq_addr),
    .arr_data(arr_data), .byte_out(next_byte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rs_valid_q <= 1'b0;
      rs_data_q  <= '0;
    end else if (accept) begin
      rs_valid_q <= 1'b1;
      rs_data_q  <= next_byte;
    end else if (rs_ready) begin
      rs_valid_q <= 1'b0;
    end
  end

  assign rs_valid = rs_valid_q;
  assign rs_data  = rs_data_q;

  p_resp_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_ready) |=> (rs_valid && $stable(rs_data)));

  p_read_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mode == MODE_READ) |=> (rs_valid && rs_data == $past(arr_data)));

  p_status_low_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mode == MODE_PROG) |=> (rs_data[4:0] == 5'd0 && !rs_data[BIT_ERR]));
endmodule

// File: tb/flash_status_reporter_test.sv
module flash_status_reporter_test;
  localparam int AW = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_start = 0, op_erase = 0, eng_done = 0, eng_timeout = 0, reset_cmd = 0;
  logic [7:0] op_data = 0, op_cell = 0, op_sectors = 0;
  logic rq_valid = 0, rs_ready = 1;
  logic [AW-1:0] rq_addr = 0;
  logic [7:0] arr_data;
  logic rq_ready, rs_valid;
  logic [7:0] rs_data;

  int checks = 0, fails = 0, cyc = 0;
  bit stall = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  // bench model state, derived from the requirements
  int m_mode = 0;          // 0 read, 1 program, 2 erase, 3 fault
  bit m_erase = 0, m_poll = 0, m_tgl = 0;
  logic [7:0] m_mask = 0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] arr_fn(input logic [AW-1:0] a);
    return a[7:0] ^ {a[AW-1 -: 3], 5'h0a};
  endfunction
  assign arr_data = arr_fn(rq_addr);

  flash_status_reporter uut (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_erase(op_erase),
    .op_data(op_data), .op_cell(op_cell), .op_sectors(op_sectors),
    .eng_done(eng_done), .eng_timeout(eng_timeout), .reset_cmd(reset_cmd),
    .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_addr(rq_addr),
    .arr_data(arr_data), .rs_valid(rs_valid), .rs_ready(rs_ready),
    .rs_data(rs_data)
  );

  task automatic check(input bit ok, input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    #1;
    cyc++;
    rs_ready = !stall || (cyc % 3 == 0);
  end

  // monitor: pop and compare on each response handshake, and check the hold rule
  bit prev_stalled = 0;
  logic [7:0] prev_data = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stalled)
        check(rs_valid && rs_data == prev_data, "R3 hold", rs_data, prev_data);
      if (rs_valid && rs_ready) begin
        if (exp_q.size() == 0) check(0, "R2 unexpected response", rs_data, 8'h00);
        else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(rs_data == e, t, rs_data, e);
        end
      end
      prev_stalled = rs_valid && !rs_ready;
      prev_data = rs_data;
    end
  end

  function automatic logic [7:0] model_byte(input logic [AW-1:0] a);
    bit prog_like, erase_like;
    prog_like  = (m_mode == 1) || (m_mode == 3 && !m_erase);
    erase_like = (m_mode == 2) || (m_mode == 3 &&  m_erase);
    if (prog_like || (erase_like && m_mask[a[AW-1 -: 3]]))
      return {m_poll, m_tgl, (m_mode == 3), 5'b0};
    return arr_fn(a);
  endfunction

  task automatic do_read(input logic [AW-1:0] a, input string tag);
    @(negedge clk);
    rq_valid = 1; rq_addr = a;
    #0;
    while (!rq_ready) @(negedge clk);
    exp_q.push_back(model_byte(a));
    tag_q.push_back(tag);
    if (m_mode != 0) m_tgl = ~m_tgl;
    @(posedge clk); #1;
    rq_valid = 0;
  endtask

  task automatic go_read;
    m_mode = 0; m_tgl = 0;
  endtask

  task automatic start_op(input bit er, input logic [7:0] d, input logic [7:0] c, input logic [7:0] msk);
    @(negedge clk);
    op_start = 1; op_erase = er; op_data = d; op_cell = c; op_sectors = msk;
    if (m_mode == 0) begin
      m_erase = er; m_poll = ~d[7] & ~er; m_mask = er ? msk : 8'h00; m_tgl = 0;
      m_mode = (!er && |(d & ~c)) ? 3 : (er ? 2 : 1);
    end
    @(negedge clk);
    op_start = 0;
  endtask

  task automatic pulse(input bit dn, input bit to, input bit rc);
    @(negedge clk);
    eng_done = dn; eng_timeout = to; reset_cmd = rc;
    if (m_mode == 1 || m_mode == 2) begin
      if (to) m_mode = 3;
      else if (dn) go_read();
    end else if (m_mode == 3 && rc) go_read();
    @(negedge clk);
    eng_done = 0; eng_timeout = 0; reset_cmd = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog", 8'h00, 8'h00);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!rs_valid, "R1 rs_valid in reset", {7'b0, rs_valid}, 8'h00);
    check(rq_ready, "R1 rq_ready in reset", {7'b0, rq_ready}, 8'h01);
    rst_n = 1;
    @(negedge clk);
    check(!rs_valid && rq_ready, "R1 idle after reset", {6'b0, rs_valid, rq_ready}, 8'h01);

    // R2: plain reads
    do_read(18'h00012, "R2 read a");
    do_read(18'h2abcd, "R2 read b");
    do_read(18'h3ffff, "R2 read c");

    // R3: back-pressure on the response channel
    stall = 1;
    for (int i = 0; i < 6; i++) do_read(AW'(i * 18'h0a51), "R3 stalled read");

    // R4/R5: program, toggle sequence under stalls
    start_op(0, 8'h35, 8'hff, 8'h00);
    for (int i = 0; i < 4; i++) do_read(AW'(18'h01000 + i), "R4 R5 program status");
    // R9: start and reset command ignored while busy
    start_op(1, 8'hff, 8'hff, 8'hff);
    pulse(0, 0, 1);
    do_read(18'h20000, "R9 ignored during program");
    // R7: done returns array data
    pulse(1, 0, 0);
    do_read(18'h01000, "R7 true data after program");
    do_read(18'h11111, "R7 read mode");

    // R6: sector erase of sectors 0 and 2
    stall = 0;
    start_op(1, 8'h00, 8'h00, 8'b0000_0101);
    do_read(18'h00100, "R6 erase sector 0 status");
    do_read(18'h08100, "R6 sector 1 array data");
    do_read(18'h10100, "R6 sector 2 status");
    do_read(18'h38000, "R6 sector 7 array data");
    // R8: timeout latches the error, toggle keeps going, done ignored
    pulse(0, 1, 0);
    do_read(18'h00200, "R8 fault status");
    do_read(18'h10200, "R8 fault toggles");
    do_read(18'h08200, "R8 fault other sector array");
    pulse(1, 0, 0);
    do_read(18'h00300, "R8 done ignored in fault");
    // R9: reset command clears the fault
    pulse(0, 0, 1);
    do_read(18'h00300, "R9 read after reset");

    // R10: program asking for a 0 -> 1 change faults at once
    start_op(0, 8'h0f, 8'h0c, 8'h00);
    do_read(18'h04444, "R10 immediate fault");
    do_read(18'h04444, "R10 fault toggles");
    pulse(0, 0, 1);
    do_read(18'h04444, "R10 read after reset");

    // R11: done and timeout together; R5 toggle restarts at 0
    start_op(0, 8'hc0, 8'hff, 8'h00);
    do_read(18'h00001, "R5 toggle restarts");
    pulse(1, 1, 0);
    do_read(18'h00001, "R11 timeout wins");
    pulse(0, 0, 1);
    do_read(18'h00001, "R11 read after reset");

    for (int i = 0; i < 50 && exp_q.size() != 0; i++) @(negedge clk);
    check(exp_q.size() == 0, "R2 all responses seen", 8'(exp_q.size()), 8'h00);
    summary();
  end
endmodule